// File: doc/BRIEF.md
# Reloading Alarm Down-Counter Timer

This block is a single-channel alarm timer that software reaches over a simple register bus. A 16-bit count register decreases by one on every cycle in which the tick-enable input is high. A tick that arrives while the count is zero is an alarm event. The alarm event raises a sticky status flag and reloads the count from a preset register, so the timer fires periodically without software taking part.

Software can read and write the count and the preset directly. It cannot write the interrupt enable bit or the status flag as values. Each of these bits has its own write-one-to-set port and its own write-one-to-clear port. Each can be read back at its own read-only address. One interrupt request line is high while both the status flag and the enable bit are set.

The bus uses byte addresses. A word register is selected only when the two low address bits are zero. Writes take effect on the rising clock edge when `wr_en` is high. Read data is combinational and is valid while `rd_en` is high.

Top module: `alarm_timer`

## Requirements
- R1: After reset the count, the preset, the status flag and the enable bit are all zero, and `irq` is low.
- R2: A write to offset 0x00 loads the count from `wr_data`, and a write to 0x04 loads the preset. Reading either offset returns the stored value.
- R3: If the count is not zero and is not being written, it decreases by one on a cycle with `tick_en` high. It holds its value on a cycle with `tick_en` low.
- R4: An alarm event is a cycle with `tick_en` high, a count of zero and no count write. On an alarm event the count takes the preset value and the status flag becomes 1.
- R5: A count write in the same cycle as a tick wins. The count takes the written value, and no decrement, reload or alarm event happens.
- R6: Writing bit 0 = 1 to offset 0x0C sets the enable bit, and writing bit 0 = 1 to 0x08 clears it. A write with bit 0 = 0 to either offset has no effect.
- R7: Writing bit 0 = 1 to offset 0x1C sets the status flag, and writing bit 0 = 1 to 0x18 clears it. A write with bit 0 = 0 to either offset has no effect.
- R8: When an alarm event and a clear-status write fall in the same cycle, the status flag ends up 1.
- R9: Offset 0x10 reads the status flag in bit 0 and offset 0x14 reads the enable bit in bit 0. Writes to these two offsets change nothing. Offsets 0x08, 0x0C, 0x18 and 0x1C read as zero, and `rd_data` is zero while `rd_en` is low.
- R10: `irq` is 1 exactly when both the status flag and the enable bit are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count tick qualifier |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, zero when no read is in progress |
| irq | output | 1 | Interrupt request |

## Verification
Counts from 1 to 6 are each run down by every tick count from zero to the full value. Comparing the read-back against start minus ticks separates a correct decrement from an off-by-one, a missed hold or an early reload. Presets 0 to 3 are each reloaded from a zero count, which shows that the status flag is set and that the value comes from the preset and not from a wrap. Same-cycle collisions test priority: a count write against a tick, and an alarm event against a clear-status write. Sweeping all four combinations of status and enable checks the interrupt line, and writes with bit 0 at zero show that the set and clear ports act only on a one.

// File: rtl/alarm_timer.sv
module alarm_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CNT  = 0, I_PRE  = 1, I_ENC = 2, I_ENS = 3,
                               I_STAT = 4, I_ENAB = 5, I_STC = 6, I_STS = 7;

  logic [CNT_W-1:0] cnt_q, preset_q;
  logic             stat_q, en_q;

  wire [IDX_W-1:0] idx     = addr[ADDR_W-1:2];
  wire             aligned = (addr[1:0] == 2'b00);
  wire             wsel    = wr_en && aligned;

  wire wr_cnt   = wsel && idx == I_CNT;
  wire wr_pre   = wsel && idx == I_PRE;
  wire en_set   = wsel && idx == I_ENS && wr_data[0];
  wire en_clr   = wsel && idx == I_ENC && wr_data[0];
  wire st_set   = wsel && idx == I_STS && wr_data[0];
  wire st_clr   = wsel && idx == I_STC && wr_data[0];
  wire zero_evt = tick_en && !wr_cnt && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      preset_q <= '0;
      stat_q   <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      if (wr_cnt)        cnt_q <= wr_data;
      else if (zero_evt) cnt_q <= preset_q;
      else if (tick_en)  cnt_q <= cnt_q - 1'b1;

      if (wr_pre) preset_q <= wr_data;

      if (st_set || zero_evt) stat_q <= 1'b1;
      else if (st_clr)        stat_q <= 1'b0;

      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && aligned) begin
      case (idx)
        I_CNT:   rd_data = cnt_q;
        I_PRE:   rd_data = preset_q;
        I_STAT:  rd_data[0] = stat_q;
        I_ENAB:  rd_data[0] = en_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign irq = stat_q & en_q;
endmodule

// File: rtl/alarm_timer_chk.sv
module alarm_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  preset,
  input logic              status,
  input logic              enable,
  input logic              irq
);
  wire c_wr_cnt = wr_en && addr == 5'h00;
  wire c_zero   = tick_en && !c_wr_cnt && cnt == '0;
  wire c_st_set = wr_en && addr == 5'h1C && wr_data[0];
  wire c_st_clr = wr_en && addr == 5'h18 && wr_data[0];
  wire c_en_set = wr_en && addr == 5'h0C && wr_data[0];

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_cnt |=> cnt == $past(wr_data)); // R5
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !c_wr_cnt && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !c_wr_cnt) |=> $stable(cnt)); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    c_zero |=> (cnt == $past(preset)) && status); // R4
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_zero && c_st_clr) |=> status); // R8
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_st_clr && !c_zero && !c_st_set) |=> !status); // R7
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    c_en_set |=> enable); // R6
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status && enable)); // R10
endmodule

bind alarm_timer alarm_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .cnt(cnt_q), .preset(preset_q), .status(stat_q),
  .enable(en_q), .irq(irq)
);

// File: tb/tb_alarm_timer.sv
module tb_alarm_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        irq;
  int          total = 0;
  int          fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_timer dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
                   .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
                   .rd_data(rd_data), .irq(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [4:0] a, logic [15:0] exp);
    rd_en = 1'b1; addr = a;
    #1;
    chk(req, rd_data, exp);
    rd_en = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 and R9: reset values and write-only offsets reading zero
    for (int a = 0; a < 32; a += 4) rd("R1", 5'(a), 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    rd_en = 1'b0; #1; chk("R9 idle read", rd_data, 16'h0);

    // R2
    wr(5'h00, 16'hABCD); rd("R2 count", 5'h00, 16'hABCD);
    wr(5'h04, 16'h5A5A); rd("R2 preset", 5'h04, 16'h5A5A);

    // R3: sweep of start values and tick counts
    for (int n = 1; n <= 6; n++)
      for (int k = 0; k <= n; k++) begin
        wr(5'h00, 16'(n));
        ticks(k);
        rd("R3 decrement", 5'h00, 16'(n - k));
        rd("R3 no alarm", 5'h10, 16'h0);
        @(negedge clk); @(negedge clk);
        rd("R3 hold", 5'h00, 16'(n - k));
      end

    // R4: reload from zero for several presets
    for (int p = 0; p < 4; p++) begin
      wr(5'h04, 16'(p)); wr(5'h00, 16'h0); wr(5'h18, 16'h1);
      rd("R4 pre", 5'h10, 16'h0);
      ticks(1);
      rd("R4 reload", 5'h00, 16'(p));
      rd("R4 status", 5'h10, 16'h1);
      wr(5'h18, 16'h1);
      ticks(p + 1);
      rd("R4 period", 5'h00, 16'(p));
      rd("R4 second alarm", 5'h10, 16'h1);
    end

    // R5: count write against tick at zero
    wr(5'h04, 16'h0009); wr(5'h00, 16'h0); wr(5'h18, 16'h1);
    @(negedge clk);
    tick_en = 1'b1; addr = 5'h00; wr_data = 16'h0007; wr_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd("R5 write wins", 5'h00, 16'h0007);
    rd("R5 no alarm", 5'h10, 16'h0);

    // R6
    wr(5'h0C, 16'hFFFE); rd("R6 set zero", 5'h14, 16'h0);
    wr(5'h0C, 16'h0001); rd("R6 set", 5'h14, 16'h1);
    wr(5'h08, 16'hFFFE); rd("R6 clr zero", 5'h14, 16'h1);
    wr(5'h08, 16'h0001); rd("R6 clr", 5'h14, 16'h0);

    // R7
    wr(5'h1C, 16'h0000); rd("R7 set zero", 5'h10, 16'h0);
    wr(5'h1C, 16'h0001); rd("R7 set", 5'h10, 16'h1);
    wr(5'h18, 16'h0002); rd("R7 clr zero", 5'h10, 16'h1);
    wr(5'h18, 16'h0001); rd("R7 clr", 5'h10, 16'h0);

    // R8: alarm event beats clear-status
    wr(5'h04, 16'h0003); wr(5'h00, 16'h0);
    @(negedge clk);
    tick_en = 1'b1; addr = 5'h18; wr_data = 16'h0001; wr_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd("R8 status kept", 5'h10, 16'h1);
    rd("R8 reloaded", 5'h00, 16'h0003);

    // R9: read-only offsets ignore writes
    wr(5'h18, 16'h1);
    wr(5'h10, 16'hFFFF); rd("R9 status ro", 5'h10, 16'h0);
    wr(5'h14, 16'hFFFF); rd("R9 enable ro", 5'h14, 16'h0);
    rd("R9 wo", 5'h1C, 16'h0);

    // R10: all status/enable combinations
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 2; e++) begin
        wr(s ? 5'h1C : 5'h18, 16'h1);
        wr(e ? 5'h0C : 5'h08, 16'h1);
        #1;
        chk("R10 irq", {15'b0, irq}, 16'(s & e));
      end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule